// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This unit resolves the control-transfer instructions of a 64-bit register machine whose instructions occupy one 64-bit slot each. For every issued instruction it reads the 8-bit opcode, the 4-bit source-register field, the 16-bit offset, the 32-bit immediate, both operand values and the current program counter (counted in instruction slots). It then reports whether control leaves the sequential path, the program counter of the next instruction, whether the instruction is a call or a return, and whether the encoding is undefined.

The opcode holds the operation code in bits [7:4], the operand-select bit in bit [3] and the class in bits [2:0]. Class 5 is the wide class and compares full 64-bit operands. Class 6 is the narrow class and compares only the low 32 bits. Operand select 0 compares against the immediate and 1 compares against the source operand. Call and return are only decoded and flagged here. Helper dispatch and the return stack belong to the pipeline around this unit.

A two-state controller sequences the unit. In ST_IDLE no result is presented. An `issue` pulse captures the decoded result at the next clock edge and moves to ST_HOLD, where `res_valid` is high. ST_HOLD stays in ST_HOLD while `issue` remains high, with a new result each cycle, and returns to ST_IDLE when `issue` is low. The last result stays on the outputs in ST_IDLE.

Top module: `bru_top`

## Requirements
- R1: After reset, `res_valid`, `taken`, `is_call`, `is_exit`, `illegal` are 0 and `next_pc` is 0.
- R2: A result is presented with `res_valid`=1 in the cycle after the edge that sampled `issue`=1. After an edge with `issue`=0, `res_valid` is 0 and the outputs keep their last values.
- R3: In class 5 a conditional branch compares all 64 bits. When bit [3] is 0, the 32-bit immediate is sign-extended to 64 bits before the compare.
- R4: In class 6 a conditional branch compares only bits [31:0] of each operand. Bits [63:32] have no effect on the outcome.
- R5: Code values select the condition: 1 equal, 5 not equal, 4 nonzero AND of the operands, 2/3/10/11 unsigned greater, greater-or-equal, less and less-or-equal, and 6/7/12/13 the same four relations on two's-complement operands.
- R6: A taken conditional branch in either class, and code 0 in class 5, go to pc + 1 + sign-extended offset. A branch that is not taken yields pc + 1. All target arithmetic wraps at the program-counter width.
- R7: Code 0 in class 6 is always taken and goes to pc + 1 + immediate. The offset field is ignored.
- R8: Code 8 is a call and is legal only in class 5 with bit [3] = 0 and a source-register field of 0, 1 or 2. A field of 1 is a local call: `taken`=1 and the target is pc + 1 + immediate. A field of 0 or 2 is an external call: `taken`=0 and the target is pc + 1. Both raise `is_call`.
- R9: Code 9 is a return and is legal only in class 5 with bit [3] = 0 and a source-register field of 0. It raises `is_exit` with `taken`=0 and a target of pc + 1.
- R10: Any other class, code 14 or 15, code 0 with bit [3]=1 or a nonzero source-register field, or a call or return outside its legal form raises `illegal`. In that case `taken`, `is_call` and `is_exit` are 0 and the target is pc + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Code [7:4], operand select [3], class [2:0] |
| src_reg | input | 4 | Source-register field (subtype for calls) |
| offset | input | 16 | Signed offset field |
| imm | input | 32 | Signed immediate field |
| dst_val | input | 64 | Destination operand value |
| src_val | input | 64 | Source operand value |
| pc | input | 32 | Program counter of the instruction, in slots |
| res_valid | output | 1 | Result presented (controller in ST_HOLD) |
| taken | output | 1 | Control leaves the sequential path |
| next_pc | output | 32 | Program counter of the next instruction |
| is_call | output | 1 | Legal call decoded |
| is_exit | output | 1 | Legal return decoded |
| illegal | output | 1 | Undefined encoding |

## Verification
Every result is due exactly one clock edge after the edge that samples `issue`, because one register stage sits between the inputs and the outputs. The bench drives each instruction on a falling edge and compares all outputs on the following falling edge. This puts the sample half a period after the capturing edge and half a period before the next one. The hold behaviour is checked one further falling edge after `issue` is dropped. At that point `res_valid` must have fallen while the other outputs remain unchanged.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

    typedef enum logic [3:0] {
        BR_ALWAYS = 4'h0, BR_EQ   = 4'h1, BR_GTU  = 4'h2, BR_GEU  = 4'h3,
        BR_TEST   = 4'h4, BR_NE   = 4'h5, BR_GTS  = 4'h6, BR_GES  = 4'h7,
        BR_CALL   = 4'h8, BR_EXIT = 4'h9, BR_LTU  = 4'ha, BR_LEU  = 4'hb,
        BR_LTS    = 4'hc, BR_LES  = 4'hd, BR_RSV14 = 4'he, BR_RSV15 = 4'hf
    } br_code_e;

    typedef enum logic [1:0] {
        DISP_NONE = 2'd0,
        DISP_OFF  = 2'd1,
        DISP_IMM  = 2'd2
    } disp_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } bru_state_e;

    typedef struct packed {
        logic eq;
        logic ltu;
        logic lts;
        logic overlap;
    } cmp_flags_t;

    function automatic logic cond_met(br_code_e c, cmp_flags_t f);
        logic r;
        case (c)
            BR_EQ:   r = f.eq;
            BR_NE:   r = !f.eq;
            BR_TEST: r = f.overlap;
            BR_GTU:  r = !f.ltu && !f.eq;
            BR_GEU:  r = !f.ltu;
            BR_LTU:  r = f.ltu;
            BR_LEU:  r = f.ltu || f.eq;
            BR_GTS:  r = !f.lts && !f.eq;
            BR_GES:  r = !f.lts;
            BR_LTS:  r = f.lts;
            BR_LES:  r = f.lts || f.eq;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bru_cmp.sv
module bru_cmp
    import bru_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output cmp_flags_t   flags
);
    always_comb begin
        flags.eq      = (a == b);
        flags.ltu     = (a < b);
        flags.lts     = ($signed(a) < $signed(b));
        flags.overlap = |(a & b);
    end
endmodule

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
(
    input  logic [7:0]  opcode,
    input  logic [3:0]  src_reg,
    input  cmp_flags_t  flags_wide,
    input  cmp_flags_t  flags_narrow,
    output logic        legal,
    output logic        take,
    output logic        call,
    output logic        ret,
    output disp_sel_e   dsel
);
    logic [2:0] cls;
    logic       use_reg;
    br_code_e   code;
    cmp_flags_t fsel;
    logic       cls_ok;

    assign cls     = opcode[2:0];
    assign use_reg = opcode[3];
    assign code    = br_code_e'(opcode[7:4]);
    assign cls_ok  = (cls == CLS_WIDE) || (cls == CLS_NARROW);
    assign fsel    = (cls == CLS_NARROW) ? flags_narrow : flags_wide;

    always_comb begin
        legal = 1'b0;
        take  = 1'b0;
        call  = 1'b0;
        ret   = 1'b0;
        dsel  = DISP_NONE;
        if (cls_ok) begin
            unique case (code)
                BR_ALWAYS: begin
                    legal = !use_reg && (src_reg == 4'd0);
                    take  = legal;
                    dsel  = (cls == CLS_WIDE) ? DISP_OFF : DISP_IMM;
                end
                BR_CALL: begin
                    legal = (cls == CLS_WIDE) && !use_reg && (src_reg <= 4'd2);
                    call  = legal;
                    take  = legal && (src_reg == 4'd1);
                    dsel  = DISP_IMM;
                end
                BR_EXIT: begin
                    legal = (cls == CLS_WIDE) && !use_reg && (src_reg == 4'd0);
                    ret   = legal;
                end
                BR_RSV14, BR_RSV15: begin
                    legal = 1'b0;
                end
                BR_EQ, BR_NE, BR_TEST, BR_GTU, BR_GEU, BR_LTU, BR_LEU,
                BR_GTS, BR_GES, BR_LTS, BR_LES: begin
                    legal = 1'b1;
                    take  = cond_met(code, fsel);
                    dsel  = DISP_OFF;
                end
            endcase
        end
    end
endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16,
    parameter int IMM_W = 32
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [IMM_W-1:0] imm,
    input  logic             take,
    input  disp_sel_e        dsel,
    output logic [PC_W-1:0]  target
);
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] disp_off;
    logic [PC_W-1:0] disp_imm;
    logic [PC_W-1:0] disp;

    assign seq_pc   = pc + PC_W'(1);
    assign disp_off = PC_W'($signed(offset));
    assign disp_imm = PC_W'($signed(imm));

    always_comb begin
        unique case (dsel)
            DISP_OFF: disp = disp_off;
            DISP_IMM: disp = disp_imm;
            default:  disp = '0;
        endcase
        target = take ? (seq_pc + disp) : seq_pc;
    end
endmodule

// File: rtl/bru_top.sv
module bru_top
    import bru_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [7:0]       opcode,
    input  logic [3:0]       src_reg,
    input  logic [OFF_W-1:0] offset,
    input  logic [XLEN/2-1:0] imm,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    input  logic [PC_W-1:0]  pc,
    output logic             res_valid,
    output logic             taken,
    output logic [PC_W-1:0]  next_pc,
    output logic             is_call,
    output logic             is_exit,
    output logic             illegal
);
    localparam int HALF = XLEN / 2;

    bru_state_e state_q, state_nx;

    logic [XLEN-1:0] b_wide;
    logic [HALF-1:0] b_narrow;
    cmp_flags_t      f_wide, f_narrow;
    logic            d_legal, d_take, d_call, d_ret;
    disp_sel_e       d_sel;
    logic [PC_W-1:0] d_target;

    assign b_wide   = opcode[3] ? src_val : XLEN'($signed(imm));
    assign b_narrow = opcode[3] ? src_val[HALF-1:0] : imm;

    bru_cmp #(.W(XLEN)) u_cmp_wide (
        .a(dst_val), .b(b_wide), .flags(f_wide)
    );

    bru_cmp #(.W(HALF)) u_cmp_narrow (
        .a(dst_val[HALF-1:0]), .b(b_narrow), .flags(f_narrow)
    );

    bru_decode u_dec (
        .opcode(opcode), .src_reg(src_reg),
        .flags_wide(f_wide), .flags_narrow(f_narrow),
        .legal(d_legal), .take(d_take), .call(d_call), .ret(d_ret),
        .dsel(d_sel)
    );

    bru_target #(.PC_W(PC_W), .OFF_W(OFF_W), .IMM_W(HALF)) u_tgt (
        .pc(pc), .offset(offset), .imm(imm),
        .take(d_take), .dsel(d_sel), .target(d_target)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_nx = issue ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_nx = issue ? ST_HOLD : ST_IDLE;
        endcase
    end

    // result registers, loaded on every issued instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken   <= 1'b0;
            next_pc <= '0;
            is_call <= 1'b0;
            is_exit <= 1'b0;
            illegal <= 1'b0;
        end else if (issue) begin
            taken   <= d_take;
            next_pc <= d_target;
            is_call <= d_call;
            is_exit <= d_ret;
            illegal <= !d_legal;
        end
    end

    assign res_valid = (state_q == ST_HOLD);
endmodule

// File: rtl/bru_checker.sv
module bru_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue,
    input logic [PC_W-1:0] pc,
    input logic            res_valid,
    input logic            taken,
    input logic [PC_W-1:0] next_pc,
    input logic            is_call,
    input logic            is_exit,
    input logic            illegal
);
    a_r2_valid_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> res_valid);

    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !res_valid);

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> ($stable(next_pc) && $stable(taken)));

    a_r6_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (taken || (next_pc == $past(pc) + PC_W'(1))));

    a_r9_exit_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && is_exit) |-> !taken);

    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && illegal) |-> (!taken && !is_call && !is_exit));

    a_r8_kind_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_call, is_exit, illegal}));
endmodule

bind bru_top bru_checker #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .issue(issue), .pc(pc),
    .res_valid(res_valid), .taken(taken), .next_pc(next_pc),
    .is_call(is_call), .is_exit(is_exit), .illegal(illegal)
);

// File: tb/tb_bru_top.sv
module tb_bru_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [7:0]  opcode = '0;
    logic [3:0]  src_reg = '0;
    logic [15:0] offset = '0;
    logic [31:0] imm = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] pc = '0;
    logic        res_valid, taken, is_call, is_exit, illegal;
    logic [31:0] next_pc;

    int checks = 0;
    int errors = 0;

    bru_top dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
        .src_reg(src_reg), .offset(offset), .imm(imm),
        .dst_val(dst_val), .src_val(src_val), .pc(pc),
        .res_valid(res_valid), .taken(taken), .next_pc(next_pc),
        .is_call(is_call), .is_exit(is_exit), .illegal(illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Expected result computed from the requirement text
    function automatic void model(
        input  logic [7:0]  op, input logic [3:0] sr, input logic [15:0] off,
        input  logic [31:0] im, input logic [63:0] d, input logic [63:0] s,
        input  logic [31:0] p,
        output logic e_ill, output logic e_tk, output logic [31:0] e_npc,
        output logic e_call, output logic e_exit, output string tag);
        logic [2:0]  cls;
        logic        xs;
        logic [3:0]  code;
        logic [63:0] ua, ub;
        logic signed [63:0] sa, sb;
        logic [31:0] disp;
        logic        hit;
        cls = op[2:0]; xs = op[3]; code = op[7:4];
        e_ill = 1'b0; e_tk = 1'b0; e_call = 1'b0; e_exit = 1'b0;
        disp = {{16{off[15]}}, off};
        tag = "R10";
        if (cls != 3'd5 && cls != 3'd6) begin
            e_ill = 1'b1;
        end else if (code == 4'd0) begin
            if (xs || sr != 0) e_ill = 1'b1;
            else begin
                e_tk = 1'b1;
                if (cls == 3'd6) begin disp = im; tag = "R7"; end
                else tag = "R6";
            end
        end else if (code == 4'd8) begin
            if (cls != 3'd5 || xs || sr > 2) e_ill = 1'b1;
            else begin
                tag = "R8"; e_call = 1'b1;
                if (sr == 1) begin e_tk = 1'b1; disp = im; end
            end
        end else if (code == 4'd9) begin
            if (cls != 3'd5 || xs || sr != 0) e_ill = 1'b1;
            else begin tag = "R9"; e_exit = 1'b1; end
        end else if (code >= 4'd14) begin
            e_ill = 1'b1;
        end else begin
            if (cls == 3'd5) begin
                tag = "R3";
                ua = d;
                ub = xs ? s : {{32{im[31]}}, im};
                sa = $signed(ua); sb = $signed(ub);
            end else begin
                tag = "R4";
                ua = {32'd0, d[31:0]};
                ub = {32'd0, (xs ? s[31:0] : im)};
                sa = $signed({{32{ua[31]}}, ua[31:0]});
                sb = $signed({{32{ub[31]}}, ub[31:0]});
            end
            case (code)
                4'd1:  hit = (ua == ub);
                4'd5:  hit = (ua != ub);
                4'd4:  hit = ((ua & ub) != 0);
                4'd2:  hit = (ua > ub);
                4'd3:  hit = (ua >= ub);
                4'd10: hit = (ua < ub);
                4'd11: hit = (ua <= ub);
                4'd6:  hit = (sa > sb);
                4'd7:  hit = (sa >= sb);
                4'd12: hit = (sa < sb);
                default: hit = (sa <= sb);
            endcase
            e_tk = hit;
        end
        e_npc = e_tk ? (p + 32'd1 + disp) : (p + 32'd1);
    endfunction

    task automatic check_out(input string tag, input logic e_v, input logic e_ill,
                             input logic e_tk, input logic [31:0] e_npc,
                             input logic e_call, input logic e_exit);
        checks++;
        if (res_valid !== e_v || illegal !== e_ill || taken !== e_tk ||
            next_pc !== e_npc || is_call !== e_call || is_exit !== e_exit) begin
            errors++;
            $display("FAIL %s op=%h sr=%0d: actual v=%b ill=%b tk=%b npc=%h call=%b exit=%b expected v=%b ill=%b tk=%b npc=%h call=%b exit=%b",
                     tag, opcode, src_reg, res_valid, illegal, taken, next_pc,
                     is_call, is_exit, e_v, e_ill, e_tk, e_npc, e_call, e_exit);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register stage)
    task automatic apply(input logic [7:0] op, input logic [3:0] sr,
                         input logic [15:0] off, input logic [31:0] im,
                         input logic [63:0] d, input logic [63:0] s,
                         input logic [31:0] p, input string force_tag);
        logic e_ill, e_tk, e_call, e_exit;
        logic [31:0] e_npc;
        string tag;
        opcode = op; src_reg = sr; offset = off; imm = im;
        dst_val = d; src_val = s; pc = p; issue = 1'b1;
        model(op, sr, off, im, d, s, p, e_ill, e_tk, e_npc, e_call, e_exit, tag);
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        issue = 1'b0;
        check_out(tag, 1'b1, e_ill, e_tk, e_npc, e_call, e_exit);
    endtask

    function automatic logic [63:0] pat_d(int i);
        case (i)
            0: return 64'd5;
            1: return 64'd7;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h0000_0000_8000_0000;
            4: return 64'h1234_0000_0000_0003;
            default: return 64'h0000_0000_0000_00F0;
        endcase
    endfunction

    function automatic logic [63:0] pat_s(int i);
        case (i)
            0: return 64'd5;
            1: return 64'd5;
            2: return 64'd1;
            3: return 64'd1;
            4: return 64'd3;
            default: return 64'h0000_0000_0000_0F0F;
        endcase
    endfunction

    function automatic logic [31:0] pat_i(int i);
        case (i)
            0: return 32'd5;
            1: return 32'd9;
            2: return 32'hFFFF_FFFF;
            3: return 32'hFFFF_FFFE;
            4: return 32'd3;
            default: return 32'h0000_0010;
        endcase
    endfunction

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check_out("R1", 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1", 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0);

        // R6: wide compare, taken with negative offset, then not taken
        apply(8'h1D, 4'd2, 16'hFFF0, 32'd0, 64'd9, 64'd9, 32'h100, "R6");
        // R2: idle edge drops valid and holds the result
        @(negedge clk);
        check_out("R2", 1'b0, 1'b0, 1'b1, 32'hF1, 1'b0, 1'b0);
        apply(8'h1D, 4'd2, 16'hFFF0, 32'd0, 64'd9, 64'd8, 32'h100, "R6");
        // R6: wide always-jump uses offset, wraps below zero
        apply(8'h05, 4'd0, 16'hFFFC, 32'd77, 64'd0, 64'd0, 32'd1, "R6");
        // R7: narrow always-jump uses immediate, ignores offset
        apply(8'h06, 4'd0, 16'h0040, 32'h1000, 64'd0, 64'd0, 32'h20, "R7");
        // R5: bit test with disjoint bits not taken, overlapping taken
        apply(8'h4D, 4'd1, 16'd4, 32'd0, 64'hF0, 64'h0F, 32'd8, "R5");
        apply(8'h4D, 4'd1, 16'd4, 32'd0, 64'hF0, 64'h18, 32'd8, "R5");
        // R5: signed less on all-ones vs zero taken, unsigned less not taken
        apply(8'hCD, 4'd1, 16'd2, 32'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'd0, "R5");
        apply(8'hAD, 4'd1, 16'd2, 32'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'd0, "R5");
        // R3: immediate -1 sign-extended equals all-ones operand
        apply(8'h15, 4'd0, 16'd3, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'd0, "R3");
        // R4: narrow equality ignores upper halves
        apply(8'h1E, 4'd1, 16'd6, 32'd0, 64'hAAAA_0000_0000_0007, 64'h5555_0000_0000_0007, 32'd0, "R4");
        // R8: local call with negative immediate, external calls fall through
        apply(8'h85, 4'd1, 16'd0, 32'hFFFF_FFFD, 64'd0, 64'd0, 32'd10, "R8");
        apply(8'h85, 4'd2, 16'd0, 32'd123, 64'd0, 64'd0, 32'd10, "R8");
        // R9: return
        apply(8'h95, 4'd0, 16'd0, 32'd0, 64'd0, 64'd0, 32'd40, "R9");
        // R10: call in narrow class and reserved code
        apply(8'h86, 4'd1, 16'd0, 32'd5, 64'd0, 64'd0, 32'd40, "R10");
        apply(8'hE5, 4'd0, 16'd5, 32'd5, 64'd0, 64'd0, 32'd40, "R10");

        // Sweep: every class, code, select bit, subtype 0..3 and operand pattern
        for (int c = 0; c < 8; c++)
            for (int k = 0; k < 16; k++)
                for (int x = 0; x < 2; x++)
                    for (int r = 0; r < 4; r++)
                        for (int q = 0; q < 6; q++)
                            apply({k[3:0], x[0], c[2:0]}, r[3:0],
                                  (q[0] ? 16'hFFF0 : 16'h0005), pat_i(q),
                                  pat_d(q), pat_s(q),
                                  (q[1] ? 32'h0000_0004 : 32'h0000_0100), "");

        // R2: valid falls after the final idle edge
        @(negedge clk);
        check_out("R2", 1'b0, illegal, taken, next_pc, is_call, is_exit);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule